// File: doc/BRIEF.md
# High-RAM Soft-Switch Controller

This block tracks the control state of a switchable upper RAM region. Bus accesses that fall in a 16-address window at 0xC080–0xC08F update three control bits: one that lets reads come from the high RAM, one that lets writes reach it, and one that chooses the second of two 4 KB banks. The block also tracks an internal arming latch. Writes become possible only after two odd-address reads in the window, with no window access between them. Both accesses count, so a single stray read cannot open the RAM to writes.

The block watches a bus strobe, a 16-bit address and a write flag. Two further addresses return status bytes that report the bank choice and the read-enable state in their top bit. The steering of memory from these bits is done elsewhere.

Top module: `bank_ram_ctrl`

## Requirements
- R1: After reset, hiWrEn is 1, bank2Sel is 1 and hiRdEn is 0.
- R2: Only an access with busValid high and busAddr in 0xC080–0xC08F changes state. Other addresses, or a cycle with busValid low, leave all outputs unchanged.
- R3: A window access at an even address (busAddr bit 0 = 0) clears hiWrEn and the arming latch. This applies to both reads and writes.
- R4: A window read at an odd address sets hiWrEn when the arming latch was already set, and then sets the latch. Two back-to-back odd reads therefore enable writing.
- R5: A window write at an odd address clears the arming latch and leaves hiWrEn unchanged.
- R6: After a window access, hiRdEn equals busAddr bit 1 when the address is odd, and the inverse of bit 1 when it is even.
- R7: After any window access, bank2Sel equals the inverse of busAddr bit 3.
- R8: State changes take effect at the rising clock edge on which busValid is high. During that cycle the outputs still show the old state.
- R9: While busValid is high with a read, address 0xC011 gives statusHit = 1 and statusData = {bank2Sel, 7'b0}, and address 0xC012 gives statusHit = 1 and statusData = {hiRdEn, 7'b0}. Any other access, including a write to either address, gives statusHit = 0 and statusData = 0.
- R10: Status reads change no state.
- R11: Accesses outside the window do not disturb the arming latch. An odd read, then an out-of-window access, then another odd read still enables writing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Bus access strobe, sampled at the clock edge |
| busAddr | input | 16 | Access address |
| busWrite | input | 1 | 1 = write, 0 = read |
| hiRdEn | output | 1 | High-RAM read enable |
| hiWrEn | output | 1 | High-RAM write enable |
| bank2Sel | output | 1 | Second-bank select |
| statusHit | output | 1 | Current access is a status readback |
| statusData | output | 8 | Status byte, flag in bit 7 |

## Verification
The hardest state to reach is the arming latch, because it is never visible at the ports. Its value can only be inferred from whether a later odd read turns hiWrEn on. Each arming scenario therefore first clears the block with an even access. It then applies a chosen run of odd reads, odd writes and out-of-window accesses, and finishes with a probing odd read whose effect on hiWrEn shows what the latch held.

// File: rtl/bank_ram_pkg.sv
package bank_ram_pkg;
  // Address bits that steer the window behaviour
  localparam int ODD_BIT  = 0;
  localparam int RD_BIT   = 1;
  localparam int BANK_BIT = 3;

  // Strobes from the decoder to the state registers
  typedef struct packed {
    logic upd;       // window access this cycle
    logic clrWr;     // drop write enable and latch
    logic setWr;     // armed odd read: enable writes
    logic preNext;   // next arming latch value
    logic rdNext;    // next read-enable value
    logic bankNext;  // next bank select
    logic statBank;  // bank status readback
    logic statRd;    // read-enable status readback
  } swCmd_t;
endpackage

// File: rtl/bank_ram_decode.sv
module bank_ram_decode
  import bank_ram_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WIN_SIZE = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hC080,
  parameter logic [ADDR_W-1:0] BANK_STAT_ADDR = 16'hC011,
  parameter logic [ADDR_W-1:0] RD_STAT_ADDR = 16'hC012
) (
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic              preArmed,
  output swCmd_t            cmd
);
  localparam int WIN_LSB = $clog2(WIN_SIZE);

  logic winHit;
  logic oddAcc;
  logic rdBit;

  always_comb begin
    winHit = busValid && (busAddr[ADDR_W-1:WIN_LSB] == WIN_BASE[ADDR_W-1:WIN_LSB]);
    oddAcc = busAddr[ODD_BIT];
    rdBit  = busAddr[RD_BIT];

    cmd.upd      = winHit;
    cmd.clrWr    = !oddAcc;
    cmd.setWr    = oddAcc && !busWrite && preArmed;
    cmd.preNext  = oddAcc && !busWrite;
    cmd.rdNext   = oddAcc ? rdBit : !rdBit;
    cmd.bankNext = !busAddr[BANK_BIT];
    cmd.statBank = busValid && !busWrite && (busAddr == BANK_STAT_ADDR);
    cmd.statRd   = busValid && !busWrite && (busAddr == RD_STAT_ADDR);
  end
endmodule

// File: rtl/bank_ram_state.sv
module bank_ram_state
  import bank_ram_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  swCmd_t            cmd,
  output logic              hiRdEn,
  output logic              hiWrEn,
  output logic              bank2Sel,
  output logic              preArmed,
  output logic              statusHit,
  output logic [DATA_W-1:0] statusData
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiWrEn   <= 1'b1;
      bank2Sel <= 1'b1;
      hiRdEn   <= 1'b0;
      preArmed <= 1'b0;
    end else if (cmd.upd) begin
      if (cmd.clrWr)      hiWrEn <= 1'b0;
      else if (cmd.setWr) hiWrEn <= 1'b1;
      preArmed <= cmd.preNext;
      hiRdEn   <= cmd.rdNext;
      bank2Sel <= cmd.bankNext;
    end
  end

  logic statFlag;
  always_comb begin
    statusHit = cmd.statBank || cmd.statRd;
    if (cmd.statBank)    statFlag = bank2Sel;
    else if (cmd.statRd) statFlag = hiRdEn;
    else                 statFlag = 1'b0;
    statusData = {statFlag, {(DATA_W-1){1'b0}}};
  end

  // R9
  status_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !statusHit |-> (statusData == '0));
endmodule

// File: rtl/bank_ram_ctrl.sv
module bank_ram_ctrl
  import bank_ram_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int WIN_SIZE = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hC080,
  parameter logic [ADDR_W-1:0] BANK_STAT_ADDR = 16'hC011,
  parameter logic [ADDR_W-1:0] RD_STAT_ADDR = 16'hC012
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  output logic              hiRdEn,
  output logic              hiWrEn,
  output logic              bank2Sel,
  output logic              statusHit,
  output logic [DATA_W-1:0] statusData
);
  localparam int WIN_LSB = $clog2(WIN_SIZE);

  swCmd_t cmd;
  logic   preArmed;

  bank_ram_decode #(
    .ADDR_W(ADDR_W), .WIN_SIZE(WIN_SIZE), .WIN_BASE(WIN_BASE),
    .BANK_STAT_ADDR(BANK_STAT_ADDR), .RD_STAT_ADDR(RD_STAT_ADDR)
  ) decode_i (
    .busValid(busValid), .busAddr(busAddr), .busWrite(busWrite),
    .preArmed(preArmed), .cmd(cmd)
  );

  bank_ram_state #(.DATA_W(DATA_W)) state_i (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .hiRdEn(hiRdEn), .hiWrEn(hiWrEn), .bank2Sel(bank2Sel),
    .preArmed(preArmed), .statusHit(statusHit), .statusData(statusData)
  );

  // Independent window view for the checks below
  logic inWin;
  assign inWin = busValid && (busAddr[ADDR_W-1:WIN_LSB] == WIN_BASE[ADDR_W-1:WIN_LSB]);

  // R2
  hold_outside_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inWin |=> ($stable(hiRdEn) && $stable(hiWrEn) && $stable(bank2Sel) && $stable(preArmed)));

  // R3
  even_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inWin && !busAddr[0]) |=> (!hiWrEn && !preArmed));

  // R4
  arm_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inWin && busAddr[0] && !busWrite && preArmed) |=> (hiWrEn && preArmed));

  // R5
  odd_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inWin && busAddr[0] && busWrite) |=> (!preArmed && (hiWrEn == $past(hiWrEn))));

  // R6
  read_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    inWin |=> (hiRdEn == ($past(busAddr[0]) ? $past(busAddr[1]) : !$past(busAddr[1]))));

  // R7
  bank_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    inWin |=> (bank2Sel == !$past(busAddr[3])));

  // R10
  status_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusHit |=> ($stable(hiRdEn) && $stable(hiWrEn) && $stable(bank2Sel)));
endmodule

// File: tb/bank_ram_ctrl_tb.sv
module bank_ram_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic [15:0] busAddr = 16'h0000;
  logic        busWrite = 1'b0;
  logic        hiRdEn, hiWrEn, bank2Sel, statusHit;
  logic [7:0]  statusData;

  int errCnt = 0;
  int chkCnt = 0;

  always #10 clk = ~clk;

  bank_ram_ctrl dut_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busAddr(busAddr),
    .busWrite(busWrite), .hiRdEn(hiRdEn), .hiWrEn(hiWrEn),
    .bank2Sel(bank2Sel), .statusHit(statusHit), .statusData(statusData)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkState(input string tag, input logic r, input logic w, input logic b);
    chk({tag, " hiRdEn"}, {7'b0, hiRdEn}, {7'b0, r});
    chk({tag, " hiWrEn"}, {7'b0, hiWrEn}, {7'b0, w});
    chk({tag, " bank2Sel"}, {7'b0, bank2Sel}, {7'b0, b});
  endtask

  // One bus access, driven at a falling edge, ends at the next falling edge
  task automatic access(input logic [15:0] a, input logic wr);
    @(negedge clk);
    busValid = 1'b1; busAddr = a; busWrite = wr;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic statusProbe(input string tag, input logic [15:0] a, input logic wr,
                             input logic expHit, input logic [7:0] expData);
    @(negedge clk);
    busValid = 1'b1; busAddr = a; busWrite = wr;
    #2;
    chk({tag, " hit"}, {7'b0, statusHit}, {7'b0, expHit});
    chk({tag, " data"}, statusData, expData);
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic t_reset;
    chkState("R1 reset", 1'b0, 1'b1, 1'b1);
    chk("R9 idle hit", {7'b0, statusHit}, 8'h00);
    // R8: update lands only at the edge
    @(negedge clk);
    busValid = 1'b1; busAddr = 16'hC080; busWrite = 1'b0;
    #5;
    chkState("R8 before edge", 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    busValid = 1'b0;
    chkState("R8 after edge", 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_even;
    access(16'hC08A, 1'b1);
    chkState("R3 R6 R7 even write", 1'b0, 1'b0, 1'b0);
    access(16'hC082, 1'b0);
    chkState("R6 R7 even read bit1", 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_arm;
    access(16'hC081, 1'b0);
    chkState("R4 first odd read", 1'b0, 1'b0, 1'b1);
    access(16'hC081, 1'b0);
    chkState("R4 second odd read", 1'b0, 1'b1, 1'b1);
    access(16'hC089, 1'b1);
    chkState("R3 odd keep then", 1'b0, 1'b1, 1'b0);
    access(16'hC088, 1'b1);
    chkState("R3 even write clears", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_odd_write;
    access(16'hC080, 1'b0);
    access(16'hC083, 1'b0);
    chkState("R6 odd bit1", 1'b1, 1'b0, 1'b1);
    access(16'hC083, 1'b1);
    chkState("R5 odd write", 1'b1, 1'b0, 1'b1);
    access(16'hC083, 1'b0);
    chkState("R5 latch was cleared", 1'b1, 1'b0, 1'b1);
    access(16'hC083, 1'b0);
    chkState("R4 rearmed", 1'b1, 1'b1, 1'b1);
    access(16'hC08B, 1'b1);
    chkState("R5 odd write keeps wr", 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_outside;
    access(16'hC070, 1'b0);
    access(16'hC090, 1'b1);
    access(16'hC07F, 1'b0);
    access(16'h4080, 1'b0);
    chkState("R2 outside window", 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    busValid = 1'b0; busAddr = 16'hC080; busWrite = 1'b0;
    @(negedge clk);
    chkState("R2 strobe low", 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_interleave;
    access(16'hC080, 1'b0);
    access(16'hC081, 1'b0);
    access(16'hC000, 1'b0);
    access(16'hC011, 1'b0);
    chkState("R11 mid", 1'b0, 1'b0, 1'b1);
    access(16'hC081, 1'b0);
    chkState("R11 arm across outside", 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_status;
    access(16'hC088, 1'b0);
    statusProbe("R9 bank clear", 16'hC011, 1'b0, 1'b1, 8'h00);
    statusProbe("R9 rd set", 16'hC012, 1'b0, 1'b1, 8'h80);
    statusProbe("R9 write no hit", 16'hC011, 1'b1, 1'b0, 8'h00);
    statusProbe("R9 other addr", 16'hC013, 1'b0, 1'b0, 8'h00);
    chkState("R10 after status", 1'b1, 1'b0, 1'b0);
    access(16'hC08A, 1'b0);
    statusProbe("R9 rd clear", 16'hC012, 1'b0, 1'b1, 8'h00);
    access(16'hC082, 1'b0);
    statusProbe("R9 bank set", 16'hC011, 1'b0, 1'b1, 8'h80);
    chkState("R10 after status 2", 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    #2000000;
    errCnt++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_even();
    t_arm();
    t_odd_write();
    t_outside();
    t_interleave();
    t_status();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule